// File: doc/BRIEF.md
# Row Scan Address Generator

This block produces the order in which rows of a display memory are read out during panel refresh. Each time the timing logic issues a line-advance strobe, the block steps to the next common (row driver) index and reports which memory row belongs on that common line. The memory row is the common index shifted by a programmable start line, wrapping around the memory height. This lets software scroll the picture vertically without rewriting memory.

The number of active common lines per frame is chosen from four fixed multiplex ratios. When the common index returns to zero, the block raises a frame-start flag. Start line and ratio requests are taken into use only at that wrap point. A frame is therefore never built from two different settings.

Top module: `row_scan_gen`

## Requirements
- R1: While `rst` is high and after its release, before any strobe: `com_idx_o` = 0, `mem_row_o` = 0, `frame_start_o` = 0. The active configuration is start line 0 and the 68-line ratio.
- R2: In a clock cycle where `line_adv_i` is low, none of `com_idx_o`, `mem_row_o` or `frame_start_o` changes at the next edge.
- R3: On a clock edge with `line_adv_i` high, `com_idx_o` increments by one. When it already equals the active line count minus one, it returns to 0 instead.
- R4: Outputs change on the clock edge that samples the strobe. After that edge, `mem_row_o` equals (active start line + `com_idx_o`) modulo 68.
- R5: A strobe that wraps `com_idx_o` to 0 sets `frame_start_o` to 1. Any other strobe clears it to 0. The flag therefore stays high for exactly one strobe interval.
- R6: `start_line_i` and `mux_mode_i` are sampled only on a wrapping strobe. Changes to them at any other time have no effect on the outputs.
- R7: A sampled `start_line_i` of 68 or more is used as 67.
- R8: The `mux_mode_i` encoding sets the active line count: 0 gives 68 lines, 1 gives 65, 2 gives 49 and 3 gives 33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_adv_i | input | 1 | Line-advance strobe, one cycle per line |
| start_line_i | input | 7 | Requested display start line |
| mux_mode_i | input | 2 | Requested multiplex ratio code |
| com_idx_o | output | 7 | Current common line index |
| mem_row_o | output | 7 | Memory row for the current common line |
| frame_start_o | output | 1 | High during the first line of each frame |

## Verification
The bench builds the block with its default parameters: a 68-row memory and ratios of 68, 65, 49 and 33 lines. With these values, one full frame of every ratio fits in a few hundred strobes. This lets the bench walk through all four encodings and every wrap of the common index. A start line of 67 paired with the 49-line ratio makes the memory row cross from 67 back to 0 in the middle of a frame. Start line requests of 100 and 127 exercise the clamp.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

    // Width of every row / line index carried through the block
    localparam int IDX_W = 7;

    typedef logic [IDX_W-1:0] idx_t;

    // Multiplex ratio selector codes
    typedef enum logic [1:0] {
        MUX_LINES_FULL = 2'd0,
        MUX_LINES_HI   = 2'd1,
        MUX_LINES_MID  = 2'd2,
        MUX_LINES_LO   = 2'd3
    } mux_mode_e;

    // Configuration in force for one frame
    typedef struct packed {
        idx_t start;   // memory row shown on common line 0
        idx_t last;    // highest common index of the frame
    } scan_cfg_t;

    // Limit a requested start line to the memory height
    function automatic idx_t clamp_start(idx_t req, int rows);
        if (int'(req) >= rows) begin
            return idx_t'(rows - 1);
        end
        return req;
    endfunction

    // Next memory row, wrapping at the memory height
    function automatic idx_t next_row(idx_t cur, int rows);
        if (cur == idx_t'(rows - 1)) begin
            return '0;
        end
        return cur + idx_t'(1);
    endfunction

endpackage

// File: rtl/scan_mode_decode.sv
module scan_mode_decode
    import rowscan_pkg::*;
#(
    parameter int LINES_FULL = 68,
    parameter int LINES_HI   = 65,
    parameter int LINES_MID  = 49,
    parameter int LINES_LO   = 33
) (
    input  mux_mode_e mode,
    output idx_t      last
);
    localparam int NUM_MODES = 4;
    localparam int LINE_TAB [NUM_MODES] = '{LINES_FULL, LINES_HI, LINES_MID, LINES_LO};

    idx_t last_tab [NUM_MODES];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_tab
        assign last_tab[g] = idx_t'(LINE_TAB[g] - 1);
    end

    assign last = last_tab[mode];
endmodule

// File: rtl/scan_cfg_latch.sv
module scan_cfg_latch
    import rowscan_pkg::*;
#(
    parameter int LINES_FULL = 68
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  scan_cfg_t nxt,
    output scan_cfg_t cur
);
    localparam scan_cfg_t RESET_CFG = '{start: '0, last: idx_t'(LINES_FULL - 1)};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RESET_CFG;
        end else if (load) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/scan_line_counter.sv
module scan_line_counter
    import rowscan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  idx_t last,
    output idx_t com,
    output logic wrap
);
    assign wrap = adv && (com == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            com <= '0;
        end else if (adv) begin
            com <= wrap ? '0 : com + idx_t'(1);
        end
    end
endmodule

// File: rtl/scan_row_mapper.sv
module scan_row_mapper
    import rowscan_pkg::*;
#(
    parameter int ROWS = 68
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic wrap,
    input  idx_t base,
    output idx_t row
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (adv) begin
            row <= wrap ? base : next_row(row, ROWS);
        end
    end
endmodule

// File: rtl/row_scan_gen.sv
module row_scan_gen
    import rowscan_pkg::*;
#(
    parameter int ROWS       = 68,
    parameter int LINES_FULL = 68,
    parameter int LINES_HI   = 65,
    parameter int LINES_MID  = 49,
    parameter int LINES_LO   = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_adv_i,
    input  logic [IDX_W-1:0] start_line_i,
    input  logic [1:0]       mux_mode_i,
    output logic [IDX_W-1:0] com_idx_o,
    output logic [IDX_W-1:0] mem_row_o,
    output logic             frame_start_o
);
    scan_cfg_t cfg_cur;
    scan_cfg_t cfg_nxt;
    idx_t      req_last;
    idx_t      act_start;
    idx_t      act_last;
    logic      wrap;

    scan_mode_decode #(
        .LINES_FULL (LINES_FULL),
        .LINES_HI   (LINES_HI),
        .LINES_MID  (LINES_MID),
        .LINES_LO   (LINES_LO)
    ) u_decode (
        .mode (mux_mode_e'(mux_mode_i)),
        .last (req_last)
    );

    always_comb begin
        cfg_nxt.start = clamp_start(start_line_i, ROWS);
        cfg_nxt.last  = req_last;
    end

    scan_cfg_latch #(
        .LINES_FULL (LINES_FULL)
    ) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (wrap),
        .nxt  (cfg_nxt),
        .cur  (cfg_cur)
    );

    assign act_start = cfg_cur.start;
    assign act_last  = cfg_cur.last;

    scan_line_counter u_count (
        .clk  (clk),
        .rst  (rst),
        .adv  (line_adv_i),
        .last (act_last),
        .com  (com_idx_o),
        .wrap (wrap)
    );

    scan_row_mapper #(
        .ROWS (ROWS)
    ) u_rows (
        .clk  (clk),
        .rst  (rst),
        .adv  (line_adv_i),
        .wrap (wrap),
        .base (cfg_nxt.start),
        .row  (mem_row_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start_o <= 1'b0;
        end else if (line_adv_i) begin
            frame_start_o <= wrap;
        end
    end
endmodule

// File: rtl/row_scan_gen_chk.sv
module row_scan_gen_chk
    import rowscan_pkg::*;
#(
    parameter int ROWS = 68
) (
    input logic clk,
    input logic rst,
    input logic strobe,
    input idx_t com_o,
    input idx_t row_o,
    input logic frame_o,
    input idx_t act_start,
    input idx_t act_last
);
    // R2: no strobe, no movement
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(com_o) && $stable(row_o) && $stable(frame_o)));

    // R3: step by one below the last index
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (strobe && com_o != act_last) |=> (int'(com_o) == int'($past(com_o)) + 1));

    // R3: return to zero at the last index
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (strobe && com_o == act_last) |=> (com_o == '0));

    // R3: index never passes the active last line
    a_r3_bound: assert property (@(posedge clk) disable iff (rst)
        com_o <= act_last);

    // R4: row is start plus index modulo memory height
    a_r4_row_map: assert property (@(posedge clk) disable iff (rst)
        int'(row_o) == (int'(act_start) + int'(com_o)) % ROWS);

    // R5: flag only on the first line
    a_r5_frame_top: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> (com_o == '0));

    // R5: wrapping strobe raises the flag
    a_r5_frame_rise: assert property (@(posedge clk) disable iff (rst)
        (strobe && com_o == act_last) |=> frame_o);

    // R6: configuration frozen except on a wrap
    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !(strobe && com_o == act_last) |=> ($stable(act_start) && $stable(act_last)));

    // R7: active start always inside the memory
    a_r7_clamp: assert property (@(posedge clk) disable iff (rst)
        int'(act_start) < ROWS);
endmodule

bind row_scan_gen row_scan_gen_chk #(
    .ROWS (ROWS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strobe    (line_adv_i),
    .com_o     (com_idx_o),
    .row_o     (mem_row_o),
    .frame_o   (frame_start_o),
    .act_start (act_start),
    .act_last  (act_last)
);

// File: tb/row_scan_gen_test.sv
`timescale 1ns/1ps
module row_scan_gen_test;
    localparam int ROWS = 68;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic [6:0] start_in = '0;
    logic [1:0] mode_in = '0;
    logic [6:0] com_o;
    logic [6:0] row_o;
    logic       frame_o;

    int n_checks = 0;
    int n_errs   = 0;

    // Reference model state
    int m_com = 0;
    int m_row = 0;
    int m_start = 0;
    int m_lines = 68;
    bit m_frame = 0;

    typedef struct {
        int    com;
        int    row;
        bit    frame;
        string tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    row_scan_gen uut (
        .clk           (clk),
        .rst           (rst),
        .line_adv_i    (strobe),
        .start_line_i  (start_in),
        .mux_mode_i    (mode_in),
        .com_idx_o     (com_o),
        .mem_row_o     (row_o),
        .frame_start_o (frame_o)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    endtask

    function automatic int lines_of(int code);
        case (code)
            0: return 68;
            1: return 65;
            2: return 49;
            default: return 33;
        endcase
    endfunction

    // Driver: one strobe, expected result queued
    task automatic step(string tag);
        @(negedge clk);
        if (m_com == m_lines - 1) begin
            m_com   = 0;
            m_start = (int'(start_in) >= ROWS) ? ROWS - 1 : int'(start_in);
            m_lines = lines_of(int'(mode_in));
            m_row   = m_start;
            m_frame = 1;
        end else begin
            m_com   = m_com + 1;
            m_row   = (m_row + 1) % ROWS;
            m_frame = 0;
        end
        q.push_back('{m_com, m_row, m_frame, tag});
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // R2: idle cycles leave outputs untouched
    task automatic idle_check();
        repeat (4) @(negedge clk);
        check("R2 com hold", int'(com_o), m_com);
        check("R2 row hold", int'(row_o), m_row);
        check("R2 frame hold", int'(frame_o), int'(m_frame));
    endtask

    // Monitor: compare after each sampled strobe
    initial begin
        forever begin
            @(posedge clk);
            if (strobe === 1'b1 && rst === 1'b0) begin
                @(negedge clk);
                if (q.size() == 0) begin
                    n_checks++;
                    n_errs++;
                    $display("FAIL R3: actual output change expected none queued");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({"R3 com ", e.tag}, int'(com_o), e.com);
                    check({"R4 row ", e.tag}, int'(row_o), e.row);
                    check({"R5 frame ", e.tag}, int'(frame_o), int'(e.frame));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, requests that must be ignored during reset
        start_in = 7'd9;
        mode_in  = 2'd3;
        repeat (3) @(negedge clk);
        check("R1 com in reset", int'(com_o), 0);
        check("R1 row in reset", int'(row_o), 0);
        check("R1 frame in reset", int'(frame_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 com after release", int'(com_o), 0);
        check("R1 row after release", int'(row_o), 0);
        check("R1 frame after release", int'(frame_o), 0);

        // R6: first frame still 68 lines, start 0, despite new requests
        run(40, "R6 first frame");
        idle_check();
        run(27, "R6 first frame");
        check("R6 last line row", int'(row_o), 67);
        // Wrap takes start 9, mode 3 = 33 lines (R8)
        run(1, "R8 wrap to 33");
        check("R8 wrap row", int'(row_o), 9);
        check("R5 wrap flag", int'(frame_o), 1);
        idle_check();

        // 33-line frame, requests changed mid frame
        run(10, "R8 33 lines");
        start_in = 7'd100;
        mode_in  = 2'd2;
        run(22, "R6 mid change");
        check("R8 33-line last index", int'(com_o), 32);
        run(1, "R7 clamp 100");
        check("R7 clamped start", int'(row_o), 67);

        // 49-line frame crossing memory row 67 to 0
        run(20, "R4 row wrap");
        start_in = 7'd30;
        mode_in  = 2'd1;
        run(29, "R4 49 lines");
        check("R8 49-line restart", int'(com_o), 0);

        // 65-line frame from start 30
        run(64, "R8 65 lines");
        check("R4 65-line last row", int'(row_o), 26);
        start_in = 7'd127;
        mode_in  = 2'd0;
        run(1, "R7 clamp 127");
        check("R7 clamp 127 row", int'(row_o), 67);

        // Full 68-line frame and one more wrap
        run(68, "R3 68 lines");
        idle_check();

        repeat (3) @(negedge clk);
        check("R3 queue drained", q.size(), 0);
        summary();
        $finish;
    end
endmodule